// File: doc/BRIEF.md
# Variable-group carry-select adder

This block is a purely combinational 20-bit adder. It takes two operands and a carry-in, and it produces the sum and the carry-out. The operand bits are split into groups whose widths grow by one bit from the least-significant end: 2, 3, 4, 5 and then 6 bits.

The bottom group is a plain ripple chain fed by the true carry-in. Every group above it builds two complete carry chains side by side. One chain assumes an incoming carry of 0 and the other assumes 1. The carry that actually arrives from the group below then drives a multiplexer, which picks that group's sums and carry-out from the matching chain. All of the dual chains are evaluated at the same time. As a result, the slow path is one short ripple followed by a string of multiplexers.

Inside every chain, each bit forms a generate term from AND and a propagate term from XOR. The carry into the next bit is generate OR (propagate AND carry), and each sum bit is propagate XOR the incoming carry. The group widths come from one packed parameter. An equal-width split such as five 4-bit groups is therefore only a matter of parameter values.

Top module: `var_csel_adder`

## Requirements
- R1: For every pair of operands and every carry-in, {cout, sum} equals opa + opb + cin computed at 21 bits.
- R2: With default parameters, the groups cover bits 0–1, 2–4, 5–8, 9–13 and 14–19. A carry that crosses each of the boundaries at bit 2, 5, 9 and 14 still gives the correct sum.
- R3: The lowest group uses a single carry chain driven straight from cin. With cin = 1 and zero operands, sum = 1. With opa = 3, opb = 0 and cin = 1, sum = 4.
- R4: Each upper group computes two results, one for carry-in 0 and one for carry-in 1. The carry-in-1 result equals the carry-in-0 result plus one, and the arriving carry selects between them.
- R5: Within a chain, generate = a AND b, propagate = a XOR b, sum = propagate XOR carry. Each chain's {carry-out, sum} equals the arithmetic sum of its own inputs.
- R6: cout is the carry selected by the top group. It is 1 exactly when opa + opb + cin reaches 2^20, for example 0x80000 + 0x80000.
- R7: All-ones operands with cin = 1 give sum = 0xFFFFF and cout = 1. One all-ones operand, a zero operand and cin = 1 give sum = 0 and cout = 1.
- R8: The carry that each group passes upward, together with the sum bits below it, equals the sum of the operand bits below that boundary plus cin.
- R9: Setting the width table to 4, 4, 4, 4, 4 yields an adder whose results are identical to those of the default split.
- R10: The widths in the table must add up to WIDTH, and every width must be at least one. This is checked when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 20 | First operand |
| opb | input | 20 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 20 | Sum bits |
| cout | output | 1 | Carry out of bit 19 |

## Verification
The hardest case to reach from the ports is a carry that is born in the lowest group and has to pass through every multiplexer. That only happens when every bit above it propagates, so that the selection in each group depends on the group below. Random operands almost never produce such long propagate runs. The directed stimulus therefore builds operands that are all ones up to a chosen boundary, adds one at bit 0, and moves the boundary across every group edge. It also includes the fully propagating case of all ones plus a carry-in. Each test drives a default-split instance and an equal-split instance together, so the two configurations are compared on the same operands.

// File: rtl/csel_pkg.sv
package csel_pkg;

  localparam int GW_BITS = 8;

  function automatic logic gen_f(input logic a, input logic b);
    return a & b;
  endfunction

  function automatic logic prop_f(input logic a, input logic b);
    return a ^ b;
  endfunction

  function automatic logic carry_f(input logic g, input logic p, input logic c);
    return g | (p & c);
  endfunction

  function automatic logic sum_f(input logic p, input logic c);
    return p ^ c;
  endfunction

endpackage

// File: rtl/csel_chain.sv
module csel_chain #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import csel_pkg::*;

  logic [W:0]   c;
  logic [W-1:0] g_bit;
  logic [W-1:0] p_bit;

  assign c[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit_slice
    assign g_bit[i] = gen_f(a[i], b[i]);
    assign p_bit[i] = prop_f(a[i], b[i]);
    assign c[i+1]   = carry_f(g_bit[i], p_bit[i], c[i]);
    assign sum[i]   = sum_f(p_bit[i], c[i]);
  end

  assign cout = c[W];

  // R5: the chain result matches plain arithmetic on its own inputs
  always_comb begin
    a_r5_chain_arith: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
      else $error("chain result differs from arithmetic sum");
  end

endmodule

// File: rtl/csel_group.sv
module csel_group #(
  parameter int W    = 4,
  parameter bit DUAL = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  if (DUAL) begin : g_dual
    logic [W-1:0] sum_c0;
    logic [W-1:0] sum_c1;
    logic         co_c0;
    logic         co_c1;

    csel_chain #(.W(W)) u_chain0 (
      .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(co_c0)
    );
    csel_chain #(.W(W)) u_chain1 (
      .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(co_c1)
    );

    assign sum  = cin ? sum_c1 : sum_c0;
    assign cout = cin ? co_c1  : co_c0;

    // R4: the carry-in-1 result is the carry-in-0 result plus one
    always_comb begin
      a_r4_pair_plus_one: assert ({co_c1, sum_c1} == ({co_c0, sum_c0} + {{W{1'b0}}, 1'b1}))
        else $error("precomputed pair inconsistent");
    end
  end else begin : g_single
    // R3: one chain, fed by the true incoming carry
    csel_chain #(.W(W)) u_chain (
      .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );
  end

endmodule

// File: rtl/var_csel_adder.sv
module var_csel_adder #(
  parameter int                                WIDTH = 20,
  parameter int                                NGRP  = 5,
  parameter logic [NGRP*csel_pkg::GW_BITS-1:0] GW    = {8'd6, 8'd5, 8'd4, 8'd3, 8'd2}
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import csel_pkg::*;

  function automatic int grp_w(input int k);
    return int'(GW[k*GW_BITS +: GW_BITS]);
  endfunction

  function automatic int grp_lo(input int k);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += grp_w(j);
    return acc;
  endfunction

  localparam int TOTAL = grp_lo(NGRP);

  // carry entering each group; grp_c[NGRP] is the final carry
  logic [NGRP:0] grp_c;
  assign grp_c[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = grp_lo(g);
    localparam int W  = grp_w(g);
    localparam int HI = LO + W - 1;

    csel_group #(.W(W), .DUAL(g != 0)) u_grp (
      .a   (opa[HI:LO]),
      .b   (opb[HI:LO]),
      .cin (grp_c[g]),
      .sum (sum[HI:LO]),
      .cout(grp_c[g+1])
    );

    logic [HI+1:0] low_ref;
    assign low_ref = {1'b0, opa[HI:0]} + {1'b0, opb[HI:0]} + {{(HI+1){1'b0}}, cin};

    // R8: carry leaving this boundary agrees with the sum of all bits below
    always_comb begin
      a_r8_boundary_carry: assert ({grp_c[g+1], sum[HI:0]} == low_ref)
        else $error("group boundary carry wrong");
    end
  end

  assign cout = grp_c[NGRP];

  // R1 / R6: whole-word result and carry-out
  always_comb begin
    a_r1_total_sum: assert ({cout, sum} == ({1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin}))
      else $error("adder result wrong");
  end

  // R10: the width table must exactly tile the word
  initial begin
    a_r10_table_tiles: assert (TOTAL == WIDTH)
      else $error("group widths do not add up to WIDTH");
    for (int k = 0; k < NGRP; k++) begin
      a_r10_width_nonzero: assert (grp_w(k) > 0)
        else $error("zero-width group");
    end
  end

endmodule

// File: tb/var_csel_adder_test.sv
module var_csel_adder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] opa, opb;
  logic        cin;
  logic [19:0] sum, sum_eq;
  logic        cout, cout_eq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  var_csel_adder uut (
    .opa(opa), .opb(opb), .cin(cin), .sum(sum), .cout(cout)
  );

  // R9: equal-width configuration
  var_csel_adder #(.WIDTH(20), .NGRP(5), .GW({8'd4, 8'd4, 8'd4, 8'd4, 8'd4})) uut_eq (
    .opa(opa), .opb(opb), .cin(cin), .sum(sum_eq), .cout(cout_eq)
  );

  task automatic apply(input string tag, input logic [19:0] a, input logic [19:0] b,
                       input logic c);
    logic [20:0] exp;
    @(posedge clk);
    opa = a; opb = b; cin = c;
    @(negedge clk);
    exp = {1'b0, a} + {1'b0, b} + {20'd0, c};
    n_chk++;
    if ({cout, sum} !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%h b=%h c=%0d actual=%h expected=%h", tag, a, b, c, {cout, sum}, exp);
    end
    n_chk++;
    if ({cout_eq, sum_eq} !== exp) begin
      n_bad++;
      $display("FAIL R9 (%s): equal split actual=%h expected=%h", tag, {cout_eq, sum_eq}, exp);
    end
  endtask

  task automatic t_reset_state();
    apply("R1 reset zeros", 20'h0, 20'h0, 1'b0);
  endtask

  task automatic t_low_group();
    apply("R3 cin only", 20'h0, 20'h0, 1'b1);
    apply("R3 low group full", 20'h3, 20'h0, 1'b1);
    apply("R3 low generate", 20'h3, 20'h3, 1'b0);
  endtask

  task automatic t_boundaries();
    int edges [4] = '{2, 5, 9, 14};
    foreach (edges[k]) begin
      logic [19:0] ones;
      ones = (20'h1 << edges[k]) - 20'h1;
      apply("R2 R8 crossing", ones, 20'h1, 1'b0);
      apply("R2 R8 crossing cin", ones, 20'h0, 1'b1);
      apply("R2 R8 generate at edge", 20'h1 << (edges[k] - 1), 20'h1 << (edges[k] - 1), 1'b0);
    end
  endtask

  task automatic t_all_ones();
    apply("R7 ones plus ones plus cin", 20'hFFFFF, 20'hFFFFF, 1'b1);
    apply("R7 ones plus cin", 20'hFFFFF, 20'h0, 1'b1);
    apply("R7 ones plus one", 20'h1, 20'hFFFFF, 1'b0);
  endtask

  task automatic t_carry_out();
    apply("R6 msb overflow", 20'h80000, 20'h80000, 1'b0);
    apply("R6 just below", 20'h7FFFF, 20'h80000, 1'b0);
    apply("R6 just reaches", 20'h7FFFF, 20'h80000, 1'b1);
  endtask

  task automatic t_pairs();
    apply("R4 R5 alternating", 20'hAAAAA, 20'h55555, 1'b1);
    apply("R4 R5 alt no cin", 20'hAAAAA, 20'h55555, 1'b0);
    apply("R4 R5 upper prop", 20'hFC000, 20'h03FFF, 1'b1);
  endtask

  task automatic t_random();
    logic [31:0] lfsr = 32'hACE1_2468;
    for (int i = 0; i < 200; i++) begin
      logic [19:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr[19:0];
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr[27:8];
      apply("R1 random", ra, rb, lfsr[3]);
    end
  endtask

  initial begin
    opa = '0; opb = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_low_group();
    t_boundaries();
    t_all_ones();
    t_carry_out();
    t_pairs();
    t_random();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule